// File: doc/BRIEF.md
# Polar Amplitude and Phase Limiter

This block corrects one frequency-domain subcarrier sample against the constellation point it was meant to carry. Both the received I/Q value and the reference point go through an iterative CORDIC in vectoring mode, which yields a magnitude and a 16-bit binary angle for each. The magnitude of the sample is then held within a programmable distance of the reference magnitude. Its angle is held within a programmable angular distance of the reference angle, with the difference taken modulo a full turn. A CORDIC in rotation mode then rebuilds I/Q from the limited polar pair.

The sample is never snapped onto the reference. A sample already inside both bounds leaves the block unchanged, apart from rounding. This keeps most of the clipping correction done upstream, so the removed peak does not come back. A symbol's 64 subcarriers are fed one at a time through a valid/ready stream. The two limits are sampled with each accepted sample. Only one sample is in flight: the input is refused from acceptance until the result has been taken.

Top module: `pl_polar_limiter`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: After a sample is accepted (`in_valid` and `in_ready` at a rising edge), `in_ready` stays 0 until the corresponding result has been taken (`out_valid` and `out_ready` at a rising edge).
- R3: The output magnitude is the input magnitude clamped to the interval from max(0, Aref − `lim_amp`) to Aref + `lim_amp`. Aref is the reference magnitude, and magnitudes are in the same LSB units as I and Q.
- R4: The output angle is the input angle clamped to within ±`lim_phase` of the reference angle. Angles are binary angles where 65536 is a full turn. The deviation is measured as the signed difference modulo a full turn, so a clamp across ±180° goes the short way round.
- R5: A sample that lies within both bounds is passed through with its own magnitude and angle (within ±12 LSB per component), not moved toward the reference.
- R6: When the reference is exactly (0,0), the angle of the input is kept unchanged and only the magnitude clamp to [0, `lim_amp`] applies.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_i` and `out_q` keep their values.
- R8: A rebuilt component outside the signed range of `out_i`/`out_q` saturates to the nearest representable value (+32767 or −32768 at the default width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Block idle and able to accept a pair |
| in_i | input | DW | Received in-phase component, signed |
| in_q | input | DW | Received quadrature component, signed |
| ref_i | input | DW | Reference in-phase component, signed |
| ref_q | input | DW | Reference quadrature component, signed |
| lim_amp | input | DW | Allowed magnitude deviation, unsigned, sampled on acceptance |
| lim_phase | input | 15 | Allowed angle deviation in binary-angle units, sampled on acceptance |
| out_valid | output | 1 | Limited sample available |
| out_ready | input | 1 | Consumer takes the limited sample |
| out_i | output | DW | Limited in-phase component, signed |
| out_q | output | DW | Limited quadrature component, signed |

## Verification
The hardest case to reach from the ports is an angle clamp whose window straddles the ±180° seam. There the raw angle difference overflows and must wrap before comparison. Directed pairs place the reference at +170° and the input at −170°. A further directed case drives a large clamped magnitude onto the real axis so the rebuilt component must saturate. Random pairs are kept away from near-zero magnitudes and from exactly opposite angles, where the expected result is ill-conditioned.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int ANG_W = 16;
  // 1/K of the CORDIC gain in Q15
  localparam logic [15:0] INV_GAIN_Q15 = 16'd19898;

  typedef enum logic [2:0] {ST_IDLE, ST_VEC, ST_ROT, ST_OUT} pl_state_e;

  // arctan(2^-k) as binary angle, 65536 per turn
  function automatic logic [ANG_W-1:0] pl_atan(input int unsigned k);
    case (k)
      0:  pl_atan = 16'd8192;
      1:  pl_atan = 16'd4836;
      2:  pl_atan = 16'd2555;
      3:  pl_atan = 16'd1297;
      4:  pl_atan = 16'd651;
      5:  pl_atan = 16'd326;
      6:  pl_atan = 16'd163;
      7:  pl_atan = 16'd81;
      8:  pl_atan = 16'd41;
      9:  pl_atan = 16'd20;
      10: pl_atan = 16'd10;
      11: pl_atan = 16'd5;
      12: pl_atan = 16'd3;
      13: pl_atan = 16'd1;
      14: pl_atan = 16'd1;
      default: pl_atan = 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/pl_cordic_vec.sv
module pl_cordic_vec #(
  parameter int DW   = 16,
  parameter int ITER = 16,
  parameter int GB   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] yi,
  output logic                 done,
  output logic [DW:0]          mag,
  output logic [15:0]          ang
);
  import pl_pkg::*;
  localparam int XW = DW + GB + 3;
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int PW = XW + 17;

  logic signed [XW-1:0] x, y, xs, ys;
  logic [15:0]          z;
  logic [CW-1:0]        cnt;
  logic                 busy;
  logic signed [PW-1:0] prod;

  assign xs = XW'(xi) <<< GB;
  assign ys = XW'(yi) <<< GB;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      x    <= '0;
      y    <= '0;
      z    <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      if (xi < 0) begin
        x <= -xs;
        y <= -ys;
        z <= 16'h8000;
      end else begin
        x <= xs;
        y <= ys;
        z <= 16'h0000;
      end
    end else if (busy) begin
      if (y < 0) begin
        x <= x - (y >>> cnt);
        y <= y + (x >>> cnt);
        z <= z - pl_atan(32'(cnt));
      end else begin
        x <= x + (y >>> cnt);
        y <= y - (x >>> cnt);
        z <= z + pl_atan(32'(cnt));
      end
      cnt <= cnt + 1'b1;
      if (cnt == CW'(ITER - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign prod = PW'(x) * $signed({1'b0, INV_GAIN_Q15});
  assign mag  = prod[15+GB +: DW+1];
  assign ang  = z;

  AST_VEC_X_NONNEG: assert property (@(posedge clk) disable iff (rst)
    busy |-> (x >= 0)); // R3
endmodule

// File: rtl/pl_cordic_rot.sv
module pl_cordic_rot #(
  parameter int DW   = 16,
  parameter int ITER = 16,
  parameter int GB   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DW:0]          amp,
  input  logic [15:0]          ang,
  output logic                 done,
  output logic signed [DW-1:0] oi,
  output logic signed [DW-1:0] oq
);
  import pl_pkg::*;
  localparam int XW = DW + GB + 3;
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int PW = DW + 17;
  localparam logic signed [XW-1:0] SMAX = XW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [XW-1:0] SMIN = -XW'(64'sd1 <<< (DW-1));

  logic signed [XW-1:0] x, y, x0, xr, yr;
  logic [15:0]          z;
  logic [CW-1:0]        cnt;
  logic                 busy;
  logic [PW-1:0]        prod;

  assign prod = PW'(amp) * PW'(INV_GAIN_Q15);
  assign x0   = XW'(prod >> (15 - GB));

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      x    <= '0;
      y    <= '0;
      z    <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      y    <= '0;
      if (ang[15] ^ ang[14]) begin
        x <= -x0;
        z <= ang + 16'h8000;
      end else begin
        x <= x0;
        z <= ang;
      end
    end else if (busy) begin
      if (!z[15]) begin
        x <= x - (y >>> cnt);
        y <= y + (x >>> cnt);
        z <= z - pl_atan(32'(cnt));
      end else begin
        x <= x + (y >>> cnt);
        y <= y - (x >>> cnt);
        z <= z + pl_atan(32'(cnt));
      end
      cnt <= cnt + 1'b1;
      if (cnt == CW'(ITER - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign xr = x >>> GB;
  assign yr = y >>> GB;
  assign oi = (xr > SMAX) ? DW'(SMAX) : (xr < SMIN) ? DW'(SMIN) : DW'(xr);
  assign oq = (yr > SMAX) ? DW'(SMAX) : (yr < SMIN) ? DW'(SMIN) : DW'(yr);
endmodule

// File: rtl/pl_clamp.sv
module pl_clamp #(
  parameter int DW = 16
) (
  input  logic [DW:0]   mag_in,
  input  logic [DW:0]   mag_ref,
  input  logic [15:0]   ph_in,
  input  logic [15:0]   ph_ref,
  input  logic [DW-1:0] lim_amp,
  input  logic [14:0]   lim_ph,
  input  logic          ref_zero,
  output logic [DW:0]   mag_o,
  output logic [15:0]   ph_o
);
  logic [DW+1:0] hi_w;
  logic [DW:0]   lo_w;
  logic [15:0]   dph, lp16;

  assign hi_w = {1'b0, mag_ref} + {2'b00, lim_amp};
  assign lo_w = (mag_ref > {1'b0, lim_amp}) ? (mag_ref - {1'b0, lim_amp}) : '0;
  assign dph  = ph_in - ph_ref;
  assign lp16 = {1'b0, lim_ph};

  always_comb begin
    if (mag_in < lo_w)              mag_o = lo_w;
    else if ({1'b0, mag_in} > hi_w) mag_o = hi_w[DW:0];
    else                            mag_o = mag_in;
  end

  always_comb begin
    if (ref_zero)                            ph_o = ph_in;
    else if ($signed(dph) > $signed(lp16))   ph_o = ph_ref + lp16;
    else if ($signed(dph) < -$signed(lp16))  ph_o = ph_ref - lp16;
    else                                     ph_o = ph_in;
  end
endmodule

// File: rtl/pl_polar_limiter.sv
module pl_polar_limiter #(
  parameter int DW   = 16,
  parameter int ITER = 16,
  parameter int GB   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [DW-1:0] ref_i,
  input  logic signed [DW-1:0] ref_q,
  input  logic [DW-1:0]        lim_amp,
  input  logic [14:0]          lim_phase,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  import pl_pkg::*;
  localparam int NV = 2;  // 0: received sample, 1: reference

  pl_state_e state;
  logic accept, rot_start, rot_done, ref_zero_q;
  logic [DW-1:0] lim_amp_q;
  logic [14:0]   lim_ph_q;
  logic [DW:0]   lmag_q, cmag;
  logic [15:0]   lph_q, cph;
  logic signed [DW-1:0] rot_i, rot_q;
  logic signed [DW-1:0] vx [NV];
  logic signed [DW-1:0] vy [NV];
  logic [DW:0]   vmag [NV];
  logic [15:0]   vang [NV];
  logic [NV-1:0] vdone;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign vx[0] = in_i;
  assign vy[0] = in_q;
  assign vx[1] = ref_i;
  assign vy[1] = ref_q;

  for (genvar g = 0; g < NV; g++) begin : g_vec
    pl_cordic_vec #(.DW(DW), .ITER(ITER), .GB(GB)) u_vec (
      .clk(clk), .rst(rst), .start(accept),
      .xi(vx[g]), .yi(vy[g]),
      .done(vdone[g]), .mag(vmag[g]), .ang(vang[g])
    );
  end

  pl_clamp #(.DW(DW)) u_clamp (
    .mag_in(vmag[0]), .mag_ref(vmag[1]),
    .ph_in(vang[0]), .ph_ref(vang[1]),
    .lim_amp(lim_amp_q), .lim_ph(lim_ph_q), .ref_zero(ref_zero_q),
    .mag_o(cmag), .ph_o(cph)
  );

  pl_cordic_rot #(.DW(DW), .ITER(ITER), .GB(GB)) u_rot (
    .clk(clk), .rst(rst), .start(rot_start),
    .amp(lmag_q), .ang(lph_q),
    .done(rot_done), .oi(rot_i), .oq(rot_q)
  );

  always_ff @(posedge clk) begin
    rot_start <= 1'b0;
    if (rst) begin
      state      <= ST_IDLE;
      out_valid  <= 1'b0;
      out_i      <= '0;
      out_q      <= '0;
      lmag_q     <= '0;
      lph_q      <= '0;
      lim_amp_q  <= '0;
      lim_ph_q   <= '0;
      ref_zero_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          lim_amp_q  <= lim_amp;
          lim_ph_q   <= lim_phase;
          ref_zero_q <= (ref_i == '0) && (ref_q == '0);
          state      <= ST_VEC;
        end
        ST_VEC: if (vdone[0]) begin
          lmag_q    <= cmag;
          lph_q     <= cph;
          rot_start <= 1'b1;
          state     <= ST_ROT;
        end
        ST_ROT: if (rot_done) begin
          out_i     <= rot_i;
          out_q     <= rot_q;
          out_valid <= 1'b1;
          state     <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checking aids
  logic [15:0] dph_chk;
  logic signed [16:0] lp_chk;
  assign dph_chk = lph_q - vang[1];
  assign lp_chk  = {2'b00, lim_ph_q};

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready)); // R1
  AST_NO_SECOND_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_BUSY_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> !in_ready); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q))); // R7
  AST_AMP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    rot_start |-> ({1'b0, lmag_q} <= {1'b0, vmag[1]} + {2'b00, lim_amp_q})); // R3
  AST_PHASE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (rot_start && !ref_zero_q) |->
      (17'($signed(dph_chk)) <= lp_chk && 17'($signed(dph_chk)) >= -lp_chk)); // R4
  AST_ZERO_REF_PHASE: assert property (@(posedge clk) disable iff (rst)
    (rot_start && ref_zero_q) |-> (lph_q == vang[0])); // R6
endmodule

// File: tb/sim_pl_polar_limiter.sv
module sim_pl_polar_limiter;
  localparam int DW  = 16;
  localparam int TOL = 12;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_i = '0, in_q = '0, ref_i = '0, ref_q = '0;
  logic [DW-1:0] lim_amp = '0;
  logic [14:0]   lim_phase = '0;
  logic signed [DW-1:0] out_i, out_q;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pl_polar_limiter #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .ref_i(ref_i), .ref_q(ref_q),
    .lim_amp(lim_amp), .lim_phase(lim_phase),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int sat(input int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  function automatic real wrap(input real a);
    real w = a;
    while (w > PI)   w -= 2.0 * PI;
    while (w <= -PI) w += 2.0 * PI;
    return w;
  endfunction

  // expected result from the requirements (R3, R4, R6, R8)
  task automatic model(input int ii, iq, ri, rq, la, lp, output int ei, output int eq);
    real mi = $sqrt(real'(ii) * ii + real'(iq) * iq);
    real mr = $sqrt(real'(ri) * ri + real'(rq) * rq);
    real ai = $atan2(real'(iq), real'(ii));
    real ar = $atan2(real'(rq), real'(ri));
    real dp = real'(lp) * 2.0 * PI / 65536.0;
    real lo = (mr - la > 0.0) ? mr - la : 0.0;
    real hi = mr + la;
    real a  = (mi < lo) ? lo : (mi > hi) ? hi : mi;
    real ph = ai;
    if (!(ri == 0 && rq == 0)) begin
      real d = wrap(ai - ar);
      if (d > dp) ph = ar + dp;
      else if (d < -dp) ph = ar - dp;
    end
    ei = sat(rnd(a * $cos(ph)));
    eq = sat(rnd(a * $sin(ph)));
  endtask

  task automatic txn(input int ii, iq, ri, rq, la, lp, input string req);
    int ei, eq, hold, hi_, hq_;
    model(ii, iq, ri, rq, la, lp, ei, eq);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_i = DW'(ii); in_q = DW'(iq); ref_i = DW'(ri); ref_q = DW'(rq);
    lim_amp = DW'(la); lim_phase = 15'(lp);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_run++;
    if (in_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: in_ready=%0b expected=0 after accept", in_ready);
    end
    while (!out_valid) begin
      @(negedge clk);
      if (!out_valid && in_ready) begin
        n_fail++;
        $display("FAIL R2: in_ready=1 expected=0 while busy");
      end
    end
    hold = int'($urandom_range(3));
    hi_ = int'(out_i); hq_ = int'(out_q);
    for (int k = 0; k < hold; k++) @(negedge clk);
    if (hold > 0) begin
      n_run++;
      if (!out_valid || int'(out_i) != hi_ || int'(out_q) != hq_) begin
        n_fail++;
        $display("FAIL R7: held=(%0d,%0d,v%0b) expected=(%0d,%0d,v1)",
                 out_i, out_q, out_valid, hi_, hq_);
      end
    end
    n_run++;
    if ((int'(out_i) - ei > TOL) || (ei - int'(out_i) > TOL) ||
        (int'(out_q) - eq > TOL) || (eq - int'(out_q) > TOL)) begin
      n_fail++;
      $display("FAIL %s: out=(%0d,%0d) expected=(%0d,%0d)", req, out_i, out_q, ei, eq);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_run++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: in_ready=%0b out_valid=%0b expected=1,0", in_ready, out_valid);
    end
    txn(10500, 5300, 10000, 5000, 3000, 2048, "R5 inside bounds");
    txn(20000, 0, 10000, 0, 2000, 1638, "R3 above window");
    txn(3000, 0, 10000, 0, 2000, 1638, "R3 below window");
    txn(0, 10000, 10000, 0, 5000, 1638, "R4 angle clamp");
    txn(-9848, -1736, -9848, 1736, 500, 910, "R4 wrap across half turn");
    txn(-9848, 1736, -9848, -1736, 500, 910, "R4 wrap other side");
    txn(3000, 4000, 0, 0, 2000, 100, "R6 zero reference");
    txn(-6000, 8000, 0, 0, 20000, 0, "R6 zero reference pass");
    txn(32767, 32767, 32767, -32767, 1000, 8192, "R8 saturation");
    for (int t = 0; t < 300; t++) begin
      int ii, iq, ri, rq, la, lp;
      real mi, mr, d;
      do begin
        ii = int'($urandom_range(40000)) - 20000;
        iq = int'($urandom_range(40000)) - 20000;
        ri = int'($urandom_range(40000)) - 20000;
        rq = int'($urandom_range(40000)) - 20000;
        mi = $sqrt(real'(ii) * ii + real'(iq) * iq);
        mr = $sqrt(real'(ri) * ri + real'(rq) * rq);
        d  = wrap($atan2(real'(iq), real'(ii)) - $atan2(real'(rq), real'(ri)));
      end while (mi < 3000.0 || mr < 3000.0 || d > PI - 0.05 || d < -PI + 0.05);
      la = int'($urandom_range(8000));
      lp = int'($urandom_range(8191));
      txn(ii, iq, ri, rq, la, lp, "R3/R4/R5 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule